// File: doc/BRIEF.md
# Stacked Register Frame Manager

This block keeps the current frame marker for a register window that slides over a physical file of stacked registers and whose size can change. The marker holds two counts: how many stacked registers the frame spans and how many of them are locals. The remaining registers of the frame are its outputs, and their count is always the span minus the locals. Next to the marker the block keeps the physical slot at which the frame begins, a saved copy of the marker from the previous frame, and the index just above the frame's top register. That index lets register accesses made relative to the top of the stack skip a subtraction.

The control logic issues one operation per cycle on a plain valid strobe. A full allocate writes both counts. A call slides the window so that the caller's outputs become the first registers of the callee and saves the caller's marker. A return brings the saved marker back and slides the window back. Grow and shrink change only the span, by an immediate amount. Any operation that would leave the frame illegal is refused: a one-cycle fault strobe is raised and the state is left as it was. The interface carries no data stream, so every pin is a plain control or status signal and there is no back-pressure. Every operation completes in one cycle.

Top module: `regframe_mgr`

## Requirements
- R1: After reset the span and the locals are 0, the frame base is physical slot 0, the saved marker is 0/0, the top index is 32 and the fault strobe is low.
- R2: A valid allocate (op code 1) with locals no greater than span and span no greater than MAX_FRAME (96 by default) loads both counts from the request. The output count always equals span minus locals.
- R3: An allocate whose locals exceed its span, or whose span exceeds MAX_FRAME, raises the fault strobe and changes no state.
- R4: A valid call (op code 2) saves the current span and locals in the previous-frame register. It makes the new span equal to the caller's outputs with zero locals, and it advances the frame base by the caller's locals, modulo PHYS_REGS.
- R5: A valid return (op code 3) loads span and locals from the previous-frame register and moves the frame base back by the restored locals, modulo PHYS_REGS. The previous-frame register keeps its value.
- R6: A valid grow (op code 4) adds its immediate to the span and leaves the locals unchanged, so the new registers are outputs. If the sum would exceed MAX_FRAME it raises the fault strobe and changes nothing.
- R7: A valid shrink (op code 5) subtracts its immediate from the span. If the immediate exceeds the span it raises the fault strobe and changes nothing. When the new span falls below the locals, the locals are cut to the new span.
- R8: The top-of-stack index always equals 32 plus the current span.
- R9: Results and the fault strobe appear in the cycle after the operation is presented. The fault strobe lasts one cycle per refused operation.
- R10: With the valid strobe low, or with op codes 0, 6 or 7, no state changes and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | 1 allocate, 2 call, 3 return, 4 grow, 5 shrink, others no-op |
| op_sof | input | FW | Requested span for allocate |
| op_sol | input | FW | Requested locals for allocate |
| op_imm | input | IMM_W | Amount for grow or shrink |
| frame_sof | output | FW | Current span |
| frame_sol | output | FW | Current locals |
| frame_outs | output | FW | Current output count |
| frame_base | output | BW | Physical slot of the frame's first register |
| tors_idx | output | TW | Register index just above the frame's top |
| pfs_sof | output | FW | Saved span of the previous frame |
| pfs_sol | output | FW | Saved locals of the previous frame |
| op_fault | output | 1 | One-cycle illegal-operation strobe |

## Verification
The bench builds the block with MAX_FRAME at its default of 96 and PHYS_REGS set to 120, which is not a power of two. With that size the compare-and-correct wrap logic is the one elaborated, and a pair of nested calls carries the frame base past the end of the physical file and back again on return. The limit of 96 lets directed tests reach the exact grow limit, one past it, and allocate requests just over it.

// File: rtl/regframe_pkg.sv
package regframe_pkg;

  typedef enum logic [2:0] {
    RF_NOP    = 3'd0,
    RF_ALLOC  = 3'd1,
    RF_CALL   = 3'd2,
    RF_RET    = 3'd3,
    RF_GROW   = 3'd4,
    RF_SHRINK = 3'd5
  } rf_op_e;

  function automatic int unsigned rf_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rf_next_frame.sv
module rf_next_frame
  import regframe_pkg::*;
#(
  parameter int MAX_FRAME = 96,
  parameter int FW        = 7,
  parameter int IMM_W     = 7
) (
  input  logic [2:0]       op_code,
  input  logic [FW-1:0]    cur_sof,
  input  logic [FW-1:0]    cur_sol,
  input  logic [FW-1:0]    prv_sof,
  input  logic [FW-1:0]    prv_sol,
  input  logic [FW-1:0]    req_sof,
  input  logic [FW-1:0]    req_sol,
  input  logic [IMM_W-1:0] imm,
  output logic [FW-1:0]    nxt_sof,
  output logic [FW-1:0]    nxt_sol,
  output logic             save_prev,
  output logic             frame_wr,
  output logic             base_move,
  output logic             base_back,
  output logic [FW-1:0]    base_delta,
  output logic             bad_op
);
  localparam int SW = int'(rf_max(FW, IMM_W)) + 1;

  rf_op_e          op;
  logic [SW-1:0]   sof_w;
  logic [SW-1:0]   imm_w;
  logic [SW-1:0]   grown;
  logic [SW-1:0]   shrunk;
  logic [FW-1:0]   shrunk_f;

  assign op       = rf_op_e'(op_code);
  assign sof_w    = SW'(cur_sof);
  assign imm_w    = SW'(imm);
  assign grown    = sof_w + imm_w;
  assign shrunk   = sof_w - imm_w;
  assign shrunk_f = shrunk[FW-1:0];

  always_comb begin
    nxt_sof    = cur_sof;
    nxt_sol    = cur_sol;
    save_prev  = 1'b0;
    frame_wr   = 1'b0;
    base_move  = 1'b0;
    base_back  = 1'b0;
    base_delta = '0;
    bad_op     = 1'b0;
    unique case (op)
      RF_ALLOC: begin
        if ((req_sof > FW'(MAX_FRAME)) || (req_sol > req_sof)) begin
          bad_op = 1'b1;
        end else begin
          nxt_sof  = req_sof;
          nxt_sol  = req_sol;
          frame_wr = 1'b1;
        end
      end
      RF_CALL: begin
        nxt_sof    = cur_sof - cur_sol;
        nxt_sol    = '0;
        save_prev  = 1'b1;
        frame_wr   = 1'b1;
        base_move  = 1'b1;
        base_delta = cur_sol;
      end
      RF_RET: begin
        nxt_sof    = prv_sof;
        nxt_sol    = prv_sol;
        frame_wr   = 1'b1;
        base_move  = 1'b1;
        base_back  = 1'b1;
        base_delta = prv_sol;
      end
      RF_GROW: begin
        if (grown > SW'(MAX_FRAME)) begin
          bad_op = 1'b1;
        end else begin
          nxt_sof  = grown[FW-1:0];
          frame_wr = 1'b1;
        end
      end
      RF_SHRINK: begin
        if (imm_w > sof_w) begin
          bad_op = 1'b1;
        end else begin
          nxt_sof  = shrunk_f;
          nxt_sol  = (shrunk_f < cur_sol) ? shrunk_f : cur_sol;
          frame_wr = 1'b1;
        end
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/rf_base_step.sv
module rf_base_step
  import regframe_pkg::*;
#(
  parameter int PHYS_REGS = 128,
  parameter int BW        = 7,
  parameter int FW        = 7
) (
  input  logic [BW-1:0] base,
  input  logic [FW-1:0] delta,
  input  logic          backward,
  output logic [BW-1:0] nxt_base
);
  localparam int  WW      = int'(rf_max(BW, FW)) + 2;
  localparam bit  IS_POW2 = ((PHYS_REGS & (PHYS_REGS - 1)) == 0);

  logic [WW-1:0] base_w;
  logic [WW-1:0] delta_w;
  logic [WW-1:0] phys_w;

  assign base_w  = WW'(base);
  assign delta_w = WW'(delta);
  assign phys_w  = WW'(PHYS_REGS);

  generate
    if (IS_POW2) begin : g_pow2
      logic [WW-1:0] raw;
      assign raw      = backward ? (base_w - delta_w) : (base_w + delta_w);
      assign nxt_base = raw[BW-1:0];
    end else begin : g_wrap
      logic [WW-1:0] fwd;
      logic [WW-1:0] bwd;
      logic [WW-1:0] sel;
      always_comb begin
        fwd = base_w + delta_w;
        if (fwd >= phys_w) fwd = fwd - phys_w;
        if (base_w >= delta_w) bwd = base_w - delta_w;
        else                   bwd = base_w + phys_w - delta_w;
        sel = backward ? bwd : fwd;
      end
      assign nxt_base = sel[BW-1:0];
    end
  endgenerate

endmodule

// File: rtl/regframe_mgr.sv
module regframe_mgr
  import regframe_pkg::*;
#(
  parameter int MAX_FRAME   = 96,
  parameter int PHYS_REGS   = 128,
  parameter int STATIC_REGS = 32,
  parameter int IMM_W       = 7,
  localparam int FW = $clog2(MAX_FRAME + 1),
  localparam int BW = $clog2(PHYS_REGS),
  localparam int TW = $clog2(STATIC_REGS + MAX_FRAME + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [FW-1:0]    op_sof,
  input  logic [FW-1:0]    op_sol,
  input  logic [IMM_W-1:0] op_imm,
  output logic [FW-1:0]    frame_sof,
  output logic [FW-1:0]    frame_sol,
  output logic [FW-1:0]    frame_outs,
  output logic [BW-1:0]    frame_base,
  output logic [TW-1:0]    tors_idx,
  output logic [FW-1:0]    pfs_sof,
  output logic [FW-1:0]    pfs_sol,
  output logic             op_fault
);
  logic [FW-1:0] sof_q, sol_q, psof_q, psol_q;
  logic [BW-1:0] base_q;
  logic [TW-1:0] tors_q;
  logic          fault_q;

  logic [FW-1:0] nxt_sof, nxt_sol, base_delta;
  logic          save_prev, frame_wr, base_move, base_back, bad_op;
  logic [BW-1:0] stepped_base;

  rf_next_frame #(
    .MAX_FRAME(MAX_FRAME), .FW(FW), .IMM_W(IMM_W)
  ) u_next (
    .op_code   (op_code),
    .cur_sof   (sof_q),
    .cur_sol   (sol_q),
    .prv_sof   (psof_q),
    .prv_sol   (psol_q),
    .req_sof   (op_sof),
    .req_sol   (op_sol),
    .imm       (op_imm),
    .nxt_sof   (nxt_sof),
    .nxt_sol   (nxt_sol),
    .save_prev (save_prev),
    .frame_wr  (frame_wr),
    .base_move (base_move),
    .base_back (base_back),
    .base_delta(base_delta),
    .bad_op    (bad_op)
  );

  rf_base_step #(
    .PHYS_REGS(PHYS_REGS), .BW(BW), .FW(FW)
  ) u_base (
    .base    (base_q),
    .delta   (base_delta),
    .backward(base_back),
    .nxt_base(stepped_base)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sof_q   <= '0;
      sol_q   <= '0;
      psof_q  <= '0;
      psol_q  <= '0;
      base_q  <= '0;
      tors_q  <= TW'(STATIC_REGS);
      fault_q <= 1'b0;
    end else begin
      fault_q <= op_valid & bad_op;
      if (op_valid) begin
        if (save_prev) begin
          psof_q <= sof_q;
          psol_q <= sol_q;
        end
        if (frame_wr) begin
          sof_q  <= nxt_sof;
          sol_q  <= nxt_sol;
          tors_q <= TW'(STATIC_REGS) + TW'(nxt_sof);
        end
        if (base_move) base_q <= stepped_base;
      end
    end
  end

  assign frame_sof  = sof_q;
  assign frame_sol  = sol_q;
  assign frame_outs = sof_q - sol_q;
  assign frame_base = base_q;
  assign tors_idx   = tors_q;
  assign pfs_sof    = psof_q;
  assign pfs_sol    = psol_q;
  assign op_fault   = fault_q;

endmodule

// File: rtl/regframe_mgr_chk.sv
module regframe_mgr_chk #(
  parameter int MAX_FRAME   = 96,
  parameter int STATIC_REGS = 32,
  parameter int FW          = 7,
  parameter int BW          = 7,
  parameter int TW          = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [2:0]    op_code,
  input logic [FW-1:0] frame_sof,
  input logic [FW-1:0] frame_sol,
  input logic [BW-1:0] frame_base,
  input logic [TW-1:0] tors_idx,
  input logic [FW-1:0] pfs_sof,
  input logic [FW-1:0] pfs_sol,
  input logic          op_fault
);
  assert_locals_fit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sol <= frame_sof);

  assert_span_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sof <= FW'(MAX_FRAME));

  assert_tors_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tors_idx == TW'(STATIC_REGS) + TW'(frame_sof));

  assert_fault_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_fault |-> (frame_sof == $past(frame_sof)) && (frame_sol == $past(frame_sol))
                 && (frame_base == $past(frame_base)));

  assert_fault_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_fault |-> $past(op_valid));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(frame_sof) && $stable(frame_sol) && $stable(frame_base) && !op_fault);

  assert_call_saves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd2) |=> (frame_sol == '0) && (pfs_sof == $past(frame_sof))
                                      && (pfs_sol == $past(frame_sol)));

  assert_ret_keeps_prev_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd3) |=> $stable(pfs_sof) && $stable(pfs_sol));

endmodule

bind regframe_mgr regframe_mgr_chk #(
  .MAX_FRAME(MAX_FRAME), .STATIC_REGS(STATIC_REGS), .FW(FW), .BW(BW), .TW(TW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .frame_sof(frame_sof), .frame_sol(frame_sol), .frame_base(frame_base),
  .tors_idx(tors_idx), .pfs_sof(pfs_sof), .pfs_sol(pfs_sol), .op_fault(op_fault)
);

// File: tb/regframe_mgr_tb.sv
module regframe_mgr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXF  = 96;
  localparam int PHYS  = 120;
  localparam int FW    = 7;
  localparam int BW    = 7;
  localparam int TW    = 8;
  localparam int IMM_W = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             op_valid = 1'b0;
  logic [2:0]       op_code = '0;
  logic [FW-1:0]    op_sof = '0;
  logic [FW-1:0]    op_sol = '0;
  logic [IMM_W-1:0] op_imm = '0;
  logic [FW-1:0]    frame_sof, frame_sol, frame_outs, pfs_sof, pfs_sol;
  logic [BW-1:0]    frame_base;
  logic [TW-1:0]    tors_idx;
  logic             op_fault;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regframe_mgr #(.MAX_FRAME(MAXF), .PHYS_REGS(PHYS), .STATIC_REGS(32), .IMM_W(IMM_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_sof(op_sof), .op_sol(op_sol), .op_imm(op_imm),
    .frame_sof(frame_sof), .frame_sol(frame_sol), .frame_outs(frame_outs),
    .frame_base(frame_base), .tors_idx(tors_idx), .pfs_sof(pfs_sof),
    .pfs_sol(pfs_sol), .op_fault(op_fault)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_frame(input string req, input int sof, input int sol, input int base,
                           input int flt);
    chk(req, "sof", int'(frame_sof), sof);
    chk(req, "sol", int'(frame_sol), sol);
    chk(req, "outs", int'(frame_outs), sof - sol);
    chk(req, "base", int'(frame_base), base);
    chk(req, "tors", int'(tors_idx), 32 + sof);
    chk(req, "fault", int'(op_fault), flt);
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic do_op(input int code, input int a, input int b, input int imm, input bit vld);
    @(negedge clk);
    op_valid = vld;
    op_code  = 3'(code);
    op_sof   = FW'(a);
    op_sol   = FW'(b);
    op_imm   = IMM_W'(imm);
    @(negedge clk);
    op_valid = 1'b0;
    op_code  = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk_frame("R1", 0, 0, 0, 0);
    chk("R1", "pfs_sof", int'(pfs_sof), 0);
    chk("R1", "pfs_sol", int'(pfs_sol), 0);
  endtask

  task automatic t_alloc_grow();
    do_reset();
    do_op(1, 20, 12, 0, 1);
    chk_frame("R2", 20, 12, 0, 0);
    do_op(4, 0, 0, 3, 1);
    chk_frame("R6", 23, 12, 0, 0);
    chk("R8", "tors after grow", int'(tors_idx), 55);
  endtask

  task automatic t_call_ret();
    do_reset();
    do_op(1, 23, 12, 0, 1);
    do_op(2, 0, 0, 0, 1);
    chk_frame("R4", 11, 0, 12, 0);
    chk("R4", "pfs_sof", int'(pfs_sof), 23);
    chk("R4", "pfs_sol", int'(pfs_sol), 12);
    do_op(3, 0, 0, 0, 1);
    chk_frame("R5", 23, 12, 0, 0);
    chk("R5", "pfs kept", int'(pfs_sof), 23);
  endtask

  task automatic t_grow_limit();
    do_reset();
    do_op(1, 90, 10, 0, 1);
    do_op(4, 0, 0, 7, 1);
    chk_frame("R6", 90, 10, 0, 1);
    do_op(0, 0, 0, 0, 1);
    chk("R9", "fault one cycle", int'(op_fault), 0);
    do_op(4, 0, 0, 6, 1);
    chk_frame("R6", 96, 10, 0, 0);
    chk("R8", "tors at limit", int'(tors_idx), 128);
  endtask

  task automatic t_shrink();
    do_reset();
    do_op(1, 5, 2, 0, 1);
    do_op(5, 0, 0, 6, 1);
    chk_frame("R7", 5, 2, 0, 1);
    do_op(5, 0, 0, 4, 1);
    chk_frame("R7", 1, 1, 0, 0);
    do_op(5, 0, 0, 1, 1);
    chk_frame("R7", 0, 0, 0, 0);
  endtask

  task automatic t_alloc_bad();
    do_reset();
    do_op(1, 30, 8, 0, 1);
    do_op(1, 10, 11, 0, 1);
    chk_frame("R3", 30, 8, 0, 1);
    do_op(1, 97, 0, 0, 1);
    chk_frame("R3", 30, 8, 0, 1);
    do_op(1, 96, 96, 0, 1);
    chk_frame("R2", 96, 96, 0, 0);
  endtask

  task automatic t_wrap();
    do_reset();
    do_op(1, 96, 96, 0, 1);
    do_op(2, 0, 0, 0, 1);
    chk_frame("R4", 0, 0, 96, 0);
    do_op(1, 40, 40, 0, 1);
    do_op(2, 0, 0, 0, 1);
    chk_frame("R4", 0, 0, 16, 0);
    do_op(3, 0, 0, 0, 1);
    chk_frame("R5", 40, 40, 96, 0);
    do_op(3, 0, 0, 0, 1);
    chk_frame("R5", 40, 40, 56, 0);
  endtask

  task automatic t_ignored();
    do_reset();
    do_op(1, 14, 4, 0, 1);
    do_op(1, 30, 10, 0, 0);
    chk_frame("R10", 14, 4, 0, 0);
    do_op(2, 0, 0, 0, 0);
    chk_frame("R10", 14, 4, 0, 0);
    do_op(6, 30, 10, 5, 1);
    chk_frame("R10", 14, 4, 0, 0);
    do_op(7, 30, 10, 5, 1);
    chk_frame("R10", 14, 4, 0, 0);
  endtask

  initial begin
    t_reset();
    t_alloc_grow();
    t_call_ret();
    t_grow_limit();
    t_shrink();
    t_alloc_bad();
    t_wrap();
    t_ignored();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule